// File: doc/BRIEF.md
# Ready-Line Wait-State Generator

This block lengthens CPU bus cycles that write to a slow peripheral. When the CPU writes inside the I/O page to the address of that peripheral, the block pulls the CPU ready input low for a fixed whole number of phase-2 cycles. The CPU therefore keeps its address, data and write strobe steady long enough for the peripheral. The system clock keeps running throughout, so anything else timed from it, such as a video address counter, is not disturbed.

The ready output comes from a flip-flop clocked on the rising edge of phase-2. It can only change just after phase two begins, which keeps it clear of the CPU's setup and hold window on that input. The length of the stall is set by a down-counter that loads the parameter `WAIT_CYCLES`. At 2 MHz the default of 8 cycles gives 4000 ns. That covers a 1800 ns strobe requirement, and the extra margin is harmless for accesses that only write.

Reads to the peripheral get no wait states. After a stall ends, the block ignores its select for one cycle, so the access that has just completed cannot start a second stall.

Top module: `rdy_stretch`

## Requirements
- R1: While `rst` is high, `rdy` is 1 and `busy` is 0. Reset takes effect at once, without waiting for a clock edge, and it abandons any stall in progress.
- R2: A write to the peripheral is qualified when, at a rising edge of `phi2`, `io_page_n`=0, `dev_match`=1 and `rw_n`=0. If the block is idle at that edge, `rdy` becomes 0 and `busy` becomes 1 just after it.
- R3: `rdy` stays 0 for exactly `WAIT_CYCLES` rising edges, counting the edge that started the stall. It returns to 1, and `busy` to 0, just after the `WAIT_CYCLES`-th edge counted from that trigger edge. The default is 8.
- R4: `rdy` and `busy` change only at a rising edge of `phi2` or on reset. An input change between edges leaves them unchanged.
- R5: With `io_page_n`=1, a write with `dev_match`=1 starts no stall.
- R6: With `dev_match`=0, a write with `io_page_n`=0 starts no stall.
- R7: A read (`rw_n`=1) to the peripheral starts no stall.
- R8: At the first edge after a stall ends, a qualifying write is ignored. At the next edge after that, a qualifying write starts a new stall.
- R9: Input values during a stall, including any mix of deselect, read and write, neither extend nor shorten it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| phi2 | input | 1 | CPU phase-2 clock; all state updates on its rising edge |
| rst | input | 1 | Asynchronous active-high reset |
| io_page_n | input | 1 | Active-low I/O page select |
| dev_match | input | 1 | High when the address selects the peripheral |
| rw_n | input | 1 | CPU read/write line, 1 = read, 0 = write |
| rdy | output | 1 | Ready line to the CPU, low while stalling |
| busy | output | 1 | High while a stall is counting |

## Verification
The bench times one full stall with the select held for the whole of it, and checks that release comes at the eighth edge, not the seventh or the ninth. A counter that is off by one would release one edge early or one edge late. The bench keeps the select asserted through the release. A design without the one-cycle lockout would restart the stall at once, and a lockout that lasted too long would miss the following write. It also tries each partial qualifier on its own: page only, match only, and a read. A decoder that dropped any term would stall on one of these. Finally, it changes inputs between edges, scrambles them during a stall, and resets in the middle of a stall, which would expose a combinational ready path or an incomplete reset.

// File: rtl/rdy_stretch.sv
module rdy_stretch #(
  parameter int WAIT_CYCLES = 8,
  localparam int CW = $clog2(WAIT_CYCLES + 1)
) (
  input  logic phi2,
  input  logic rst,
  input  logic io_page_n,
  input  logic dev_match,
  input  logic rw_n,
  output logic rdy,
  output logic busy
);

  logic [CW-1:0] cnt;
  logic          lock;
  logic          rdy_q;
  logic          start;

  assign start = !io_page_n && dev_match && !rw_n && (cnt == '0) && !lock;

  always_ff @(posedge phi2 or posedge rst) begin
    if (rst) begin
      cnt   <= '0;
      lock  <= 1'b0;
      rdy_q <= 1'b1;
    end else begin
      lock <= 1'b0;
      if (start) begin
        cnt   <= CW'(WAIT_CYCLES);
        rdy_q <= 1'b0;
      end else if (cnt != '0) begin
        cnt <= cnt - CW'(1);
        if (cnt == CW'(1)) begin
          rdy_q <= 1'b1;
          lock  <= 1'b1;
        end
      end
    end
  end

  assign rdy  = rdy_q;
  assign busy = (cnt != '0);

endmodule

// File: rtl/rdy_stretch_chk.sv
module rdy_stretch_chk #(
  parameter int CW = 4
) (
  input logic          phi2,
  input logic          rst,
  input logic          io_page_n,
  input logic          dev_match,
  input logic          rw_n,
  input logic          rdy,
  input logic          busy,
  input logic          lock,
  input logic [CW-1:0] cnt
);

  // R2
  start_chk: assert property (@(posedge phi2) disable iff (rst)
    (!busy && !lock && !io_page_n && dev_match && !rw_n) |=> (busy && !rdy));

  // R3
  count_step_chk: assert property (@(posedge phi2) disable iff (rst)
    (cnt > CW'(1)) |=> (cnt == $past(cnt) - CW'(1)) && !rdy);

  // R3
  release_chk: assert property (@(posedge phi2) disable iff (rst)
    (cnt == CW'(1)) |=> (rdy && !busy && lock));

  // R8
  lockout_chk: assert property (@(posedge phi2) disable iff (rst)
    lock |=> (!busy && !lock));

  // R5
  no_page_chk: assert property (@(posedge phi2) disable iff (rst)
    (!busy && io_page_n) |=> !busy);

  // R6
  no_match_chk: assert property (@(posedge phi2) disable iff (rst)
    (!busy && !dev_match) |=> !busy);

  // R7
  read_pass_chk: assert property (@(posedge phi2) disable iff (rst)
    (!busy && rw_n) |=> !busy);

  // R3
  rdy_busy_chk: assert property (@(posedge phi2) disable iff (rst)
    busy == !rdy);

endmodule

bind rdy_stretch rdy_stretch_chk #(.CW(CW)) chk_i (.*);

// File: tb/rdy_stretch_tb_top.sv
module rdy_stretch_tb_top;

  logic phi2 = 1'b0;
  logic rst = 1'b1;
  logic io_page_n = 1'b1;
  logic dev_match = 1'b0;
  logic rw_n = 1'b1;
  logic rdy, busy;
  int   n_run = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always #10 phi2 = ~phi2;

  rdy_stretch #(.WAIT_CYCLES(8)) dut_i (
    .phi2(phi2), .rst(rst), .io_page_n(io_page_n), .dev_match(dev_match),
    .rw_n(rw_n), .rdy(rdy), .busy(busy)
  );

  // {req[3:0], io_page_n, dev_match, rw_n, exp_rdy, exp_busy}
  localparam logic [8:0] VEC [24] = '{
    {4'd1, 3'b101, 2'b10},  // R1 idle after reset
    {4'd5, 3'b110, 2'b10},  // R5 match, no page
    {4'd6, 3'b000, 2'b10},  // R6 page, no match
    {4'd7, 3'b011, 2'b10},  // R7 read
    {4'd2, 3'b010, 2'b01},  // R2 trigger
    {4'd3, 3'b010, 2'b01},  // R3 held
    {4'd3, 3'b010, 2'b01},
    {4'd3, 3'b010, 2'b01},
    {4'd3, 3'b010, 2'b01},
    {4'd3, 3'b010, 2'b01},
    {4'd3, 3'b010, 2'b01},
    {4'd3, 3'b010, 2'b01},  // R3 seventh edge still low
    {4'd3, 3'b010, 2'b10},  // R3 release at eighth edge
    {4'd8, 3'b010, 2'b10},  // R8 lockout ignores held select
    {4'd8, 3'b010, 2'b01},  // R8 new stall
    {4'd9, 3'b101, 2'b01},  // R9 deselect mid stall
    {4'd9, 3'b011, 2'b01},
    {4'd9, 3'b110, 2'b01},
    {4'd9, 3'b000, 2'b01},
    {4'd9, 3'b010, 2'b01},
    {4'd9, 3'b101, 2'b01},
    {4'd9, 3'b101, 2'b01},
    {4'd9, 3'b101, 2'b10},  // R9 release on schedule
    {4'd1, 3'b101, 2'b10}
  };

  task automatic check(input string req, input logic exp_rdy, input logic exp_busy);
    n_run++;
    if (rdy !== exp_rdy || busy !== exp_busy) begin
      n_fail++;
      $display("FAIL %s: rdy/busy=%b%b expected %b%b", req, rdy, busy, exp_rdy, exp_busy);
    end
  endtask

  task automatic drive(input logic [2:0] v);
    {io_page_n, dev_match, rw_n} = v;
  endtask

  initial begin
    repeat (3) @(posedge phi2);
    #5;
    check("R1", 1'b1, 1'b0);
    rst = 1'b0;
    for (int i = 0; i < 24; i++) begin
      drive(VEC[i][4:2]);
      @(posedge phi2);
      #5;
      check($sformatf("R%0d vec %0d", VEC[i][8:5], i), VEC[i][1], VEC[i][0]);
    end
    // R4: change between edges, outputs hold
    drive(3'b010);
    #8;
    check("R4", 1'b1, 1'b0);
    @(posedge phi2);
    #5;
    check("R2", 1'b0, 1'b1);
    repeat (2) @(posedge phi2);
    #5;
    // R1: asynchronous reset mid stall
    rst = 1'b1;
    #2;
    check("R1", 1'b1, 1'b0);
    drive(3'b101);
    @(posedge phi2);
    #5;
    rst = 1'b0;
    @(posedge phi2);
    #5;
    check("R1", 1'b1, 1'b0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge phi2);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule